// File: doc/BRIEF.md
# Packed-Word Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software loads characters as 32-bit words rather than one byte at a time. It first writes a character count that says how many bytes of the next word are valid. It then writes the word itself. Each word and its count travel as one entry through a small word FIFO. An unpacker takes the valid bytes out of the word, least significant byte first, and hands them one at a time to a bit serializer.

The serializer runs from an external oversample strobe. Each bit lasts sixteen strobes. The frame shape is set by a six-bit format input: the number of data bits (five to eight), a parity mode, and a stop length. The stop length may be a fraction of a bit. A transmitter-empty output goes high only when no character is queued, none is being unpacked and the line is idle.

A control write carries two things. One is an enable bit, which starts transmission. The other is a five-bit channel command, split across two fields of the control word. The command value for transmitter reset aborts the frame on the line, empties the FIFO and clears the pending count.

The serializer is a state machine with five states. IDLE holds the line high. It moves to START when a byte is offered while the block is enabled. START drives the line low for one bit, then moves to DATA. DATA shifts the data bits out, least significant bit first. After the last data bit it moves to PARITY, or straight to STOP when parity is off. PARITY sends one bit, then moves to STOP. STOP holds the line high for the selected stop length, then returns to IDLE. The transmitter reset command forces IDLE from any state.

Top module: `wordtx_uart`

## Requirements
- R1: A count write (`count_in`) sets how many bytes of the next word are sent. Values 1 to 4 are used as given, 0 is treated as 1, and 5 to 7 are treated as 4. The pending count returns to 0 after every accepted or discarded word, so a word written without a new count sends one byte.
- R2: The bytes of a word are sent from bits [7:0] upward. Each frame begins with one start bit at 0. The data bits follow, least significant first.
- R3: Format bits [5:4] select the number of data bits: value n gives 5+n bits.
- R4: Format bits [1:0] select the parity bit that follows the data. 0 sends no parity bit. 1 sends odd parity, so the data and parity hold an odd number of ones. 2 sends even parity. 3 sends a parity bit that is always 0.
- R5: Start, data and parity bits each last 16 ticks. Format bits [3:2] select the stop length: 0 gives 9 ticks, 1 gives 16, 2 gives 25 and 3 gives 32. A following frame starts within two clocks after the last stop tick.
- R6: `tx_empty` is 1 exactly when no byte is queued or partly unpacked and no frame is on the line.
- R7: A control write with bit 2 set enables the transmitter. Until then queued data is held, the line stays high and `tx_empty` stays 0.
- R8: The channel command is {ctrl[11], ctrl[7:4]}. Value 2 aborts any frame, so the line is high and `tx_empty` is 1 on the next cycle, and it discards queued words and the pending count. Other command values leave the queued data untouched.
- R9: The block holds DEPTH words in the FIFO plus one word in the unpacker. A word written when the FIFO is full is discarded.
- R10: The line is high whenever no frame is being sent, including during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversample strobe, 16 per bit |
| fmt | input | 6 | Frame format: [5:4] data bits, [3:2] stop length, [1:0] parity |
| wr_count | input | 1 | Write strobe for the character count |
| count_in | input | 3 | Character count for the next word |
| wr_word | input | 1 | Write strobe for a data word |
| word_in | input | 32 | Packed characters, first character in [7:0] |
| wr_ctrl | input | 1 | Write strobe for the control word |
| ctrl_in | input | 12 | Control word: [2] enable, {[11],[7:4]} channel command |
| txd | output | 1 | Serial line output |
| tx_empty | output | 1 | Transmitter empty status |

## Verification
The assertions watch several rules on every cycle. An empty transmitter must hold the line high. A start bit may only appear once the block is enabled. The reset command must always leave the block empty on the next cycle. Any word write must make the block non-empty, and a write into a full FIFO must not free an entry. Other behaviour can only be shown by the bench scenarios, which follow a reference receiver. These cover the byte order within a word, the effect of counts 0 and 5 to 7, the parity values, the exact frame length in ticks for each stop length, and words being dropped once the storage is full.

// File: rtl/wordtx_pkg.sv
package wordtx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } ser_state_e;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_EVEN  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    localparam logic [4:0] CMD_TX_RESET = 5'd2;
    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/wordtx_fifo.sv
module wordtx_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] lvl_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (lvl_q == '0);
    assign full  = (lvl_q == LW'(DEPTH));
    assign dout  = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push) wp_q <= nxt(wp_q);
            if (pop)  rp_q <= nxt(rp_q);
            if (push && !pop)      lvl_q <= lvl_q + 1'b1;
            else if (pop && !push) lvl_q <= lvl_q - 1'b1;
        end
    end
endmodule

// File: rtl/wordtx_ser.sv
module wordtx_ser
    import wordtx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       flush,
    input  logic       go,
    input  logic [7:0] din,
    input  logic [5:0] fmt,
    output logic       idle,
    output logic       txd
);
    localparam int TW       = $clog2(2 * OSR + 1);
    localparam int ST_SHORT = (OSR * 9) / 16;
    localparam int ST_ONE   = OSR;
    localparam int ST_LONG  = OSR + ST_SHORT;
    localparam int ST_TWO   = 2 * OSR;

    ser_state_e    st_q, st_d;
    logic [TW-1:0] tcnt_q, lim;
    logic [2:0]    bit_q, last_q;
    logic [7:0]    sh_q, masked;
    logic          par_q, par_calc, bit_end;
    par_mode_e     pm_q;
    logic [1:0]    sl_q;

    assign idle    = (st_q == S_IDLE);
    assign masked  = din & (8'hFF >> (2'd3 - fmt[5:4]));
    assign bit_end = tick && (tcnt_q == lim);

    always_comb begin
        unique case (par_mode_e'(fmt[1:0]))
            PAR_ODD:  par_calc = ~^masked;
            PAR_EVEN: par_calc = ^masked;
            default:  par_calc = 1'b0;
        endcase
    end

    always_comb begin
        if (st_q == S_STOP) begin
            unique case (sl_q)
                2'd0:    lim = TW'(ST_SHORT - 1);
                2'd1:    lim = TW'(ST_ONE - 1);
                2'd2:    lim = TW'(ST_LONG - 1);
                default: lim = TW'(ST_TWO - 1);
            endcase
        end else begin
            lim = TW'(OSR - 1);
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (go) st_d = S_START;
            S_START:  if (bit_end) st_d = S_DATA;
            S_DATA:   if (bit_end && bit_q == last_q)
                          st_d = (pm_q == PAR_NONE) ? S_STOP : S_PARITY;
            S_PARITY: if (bit_end) st_d = S_STOP;
            S_STOP:   if (bit_end) st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= S_IDLE;
        else if (flush) st_q <= S_IDLE;
        else            st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            bit_q  <= '0;
            last_q <= 3'd7;
            sh_q   <= '0;
            par_q  <= 1'b0;
            pm_q   <= PAR_NONE;
            sl_q   <= 2'd1;
        end else if (flush) begin
            tcnt_q <= '0;
            bit_q  <= '0;
        end else if (idle) begin
            if (go) begin
                tcnt_q <= '0;
                bit_q  <= '0;
                last_q <= 3'd4 + {1'b0, fmt[5:4]};
                sh_q   <= masked;
                par_q  <= par_calc;
                pm_q   <= par_mode_e'(fmt[1:0]);
                sl_q   <= fmt[3:2];
            end
        end else if (tick) begin
            tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;
            if (bit_end && st_q == S_DATA) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // output logic
    always_comb begin
        unique case (st_q)
            S_START:  txd = 1'b0;
            S_DATA:   txd = sh_q[0];
            S_PARITY: txd = par_q;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/wordtx_uart.sv
module wordtx_uart
    import wordtx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OSR   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [5:0]  fmt,
    input  logic        wr_count,
    input  logic [2:0]  count_in,
    input  logic        wr_word,
    input  logic [31:0] word_in,
    input  logic        wr_ctrl,
    input  logic [11:0] ctrl_in,
    output logic        txd,
    output logic        tx_empty
);
    localparam int CW = $clog2(WORD_BYTES + 1);
    localparam int EW = CW + 32;

    logic          en_q, tx_rst, ser_idle, go;
    logic [CW-1:0] cnt_q, eff_cnt, rem_q;
    logic [31:0]   cur_q;
    logic          fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [EW-1:0] fifo_dout;
    logic          unused_ctrl;

    assign unused_ctrl = ^{ctrl_in[10:8], ctrl_in[3], ctrl_in[1:0]};
    assign tx_rst      = wr_ctrl && ({ctrl_in[11], ctrl_in[7:4]} == CMD_TX_RESET);

    always_comb begin
        if (cnt_q == '0)                  eff_cnt = CW'(1);
        else if (cnt_q > CW'(WORD_BYTES)) eff_cnt = CW'(WORD_BYTES);
        else                              eff_cnt = cnt_q;
    end

    assign fifo_push = wr_word && !fifo_full && !tx_rst;
    assign fifo_pop  = (rem_q == '0) && !fifo_empty && !tx_rst;
    assign go        = en_q && (rem_q != '0) && ser_idle && !tx_rst;
    assign tx_empty  = fifo_empty && (rem_q == '0) && ser_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
            cur_q <= '0;
            rem_q <= '0;
        end else begin
            if (wr_ctrl && ctrl_in[2]) en_q <= 1'b1;
            if (tx_rst || wr_word) cnt_q <= '0;
            else if (wr_count)     cnt_q <= count_in;
            if (tx_rst) begin
                rem_q <= '0;
            end else if (fifo_pop) begin
                cur_q <= fifo_dout[31:0];
                rem_q <= fifo_dout[EW-1:32];
            end else if (go) begin
                cur_q <= cur_q >> 8;
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    wordtx_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_rst),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   ({eff_cnt, word_in}),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    wordtx_ser #(.OSR(OSR)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .flush (tx_rst),
        .go    (go),
        .din   (cur_q[7:0]),
        .fmt   (fmt),
        .idle  (ser_idle),
        .txd   (txd)
    );
endmodule

// File: rtl/wordtx_uart_chk.sv
module wordtx_uart_chk (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic tx_empty,
    input logic wr_word,
    input logic tx_rst,
    input logic en,
    input logic fifo_full,
    input logic fifo_pop
);
    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd); // R6

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> en); // R7

    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (tx_empty && txd)); // R8

    AST_WORD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && !tx_rst) |=> !tx_empty); // R6

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_word && !tx_rst && !fifo_pop) |=> fifo_full); // R9

    AST_RESET_LINE: assert property (@(posedge clk)
        !rst_n |-> txd); // R10
endmodule

bind wordtx_uart wordtx_uart_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd       (txd),
    .tx_empty  (tx_empty),
    .wr_word   (wr_word),
    .tx_rst    (tx_rst),
    .en        (en_q),
    .fifo_full (fifo_full),
    .fifo_pop  (fifo_pop)
);

// File: tb/test_wordtx_uart.sv
`timescale 1ns/1ps
module test_wordtx_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  fmt = 6'h34;
    logic        wr_count = 1'b0;
    logic [2:0]  count_in = '0;
    logic        wr_word = 1'b0;
    logic [31:0] word_in = '0;
    logic        wr_ctrl = 1'b0;
    logic [11:0] ctrl_in = '0;
    logic        txd, tx_empty;

    always #4 clk = ~clk;

    wordtx_uart i_wordtx_uart (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt),
        .wr_count(wr_count), .count_in(count_in),
        .wr_word(wr_word), .word_in(word_in),
        .wr_ctrl(wr_ctrl), .ctrl_in(ctrl_in),
        .txd(txd), .tx_empty(tx_empty)
    );

    typedef struct {
        logic [7:0] d;
        int nd;
        int pm;
        int sm;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int total = 0;
    int bad = 0;
    int mcount = 0;
    bit inframe = 0;
    bit flushing = 0;
    bit done = 0;
    int tcnt = 0;
    int phase = 0;
    int nb, ftot, bi;
    logic expb;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int stop_t(input int sm);
        case (sm)
            0: return 9;
            1: return 16;
            2: return 25;
            default: return 32;
        endcase
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int nd, input int pm);
        logic [7:0] m;
        m = d & (8'hFF >> (8 - nd));
        if (pm == 1) return ~^m;
        if (pm == 2) return ^m;
        return 1'b0;
    endfunction

    // reference receiver and tick source, evaluated every clock
    always @(negedge clk) begin
        if (rst_n && !flushing) begin
            if (tick && inframe) tcnt++;
            if (inframe) begin
                nb = 1 + cur.nd + ((cur.pm != 0) ? 1 : 0);
                ftot = 16 * nb + stop_t(cur.sm);
                if (tcnt >= 16 * nb && (txd == 1'b0 || tx_empty)) begin
                    check(tcnt == ftot, "R5 frame length", tcnt, ftot);
                    inframe = 0;
                end else if (tick && (tcnt % 16) == 8 && tcnt < 16 * nb) begin
                    bi = tcnt / 16;
                    if (bi == 0) begin
                        check(txd == 1'b0, "R2 start bit", txd, 0);
                    end else if (bi <= cur.nd) begin
                        expb = cur.d[bi-1];
                        check(txd == expb, "R2/R3 data bit", txd, expb);
                    end else begin
                        expb = exp_par(cur.d, cur.nd, cur.pm);
                        check(txd == expb, "R4 parity bit", txd, expb);
                    end
                end else if (tick && tcnt == 16 * nb + 4) begin
                    check(txd == 1'b1, "R5 stop level", txd, 1);
                end
            end
            if (!inframe && txd == 1'b0) begin
                if (q.size() == 0) begin
                    check(0, "R10 unexpected start", 0, 1);
                end else begin
                    cur = q.pop_front();
                    inframe = 1;
                    tcnt = 0;
                end
            end
            if (tx_empty) check(!inframe && q.size() == 0, "R6 empty flag", tx_empty, 0);
        end
        phase = (phase + 1) % 3;
        tick = (phase == 0);
    end

    task automatic wr_cnt(input int c);
        @(posedge clk); #1;
        wr_count = 1'b1; count_in = 3'(c);
        @(posedge clk); #1;
        wr_count = 1'b0;
        mcount = c;
    endtask

    task automatic wr_wd(input logic [31:0] w, input bit keep);
        int n;
        exp_t e;
        @(posedge clk); #1;
        wr_word = 1'b1; word_in = w;
        @(posedge clk); #1;
        wr_word = 1'b0;
        n = (mcount == 0) ? 1 : (mcount > 4) ? 4 : mcount;
        if (keep) begin
            for (int i = 0; i < n; i++) begin
                e.d = w[8*i +: 8];
                e.nd = 5 + int'(fmt[5:4]);
                e.pm = int'(fmt[1:0]);
                e.sm = int'(fmt[3:2]);
                q.push_back(e);
            end
        end
        mcount = 0;
    endtask

    task automatic wr_ctl(input logic [11:0] v, input bit flush);
        @(posedge clk); #1;
        if (flush) flushing = 1;
        wr_ctrl = 1'b1; ctrl_in = v;
        @(posedge clk); #1;
        wr_ctrl = 1'b0;
        if (flush) begin
            q.delete();
            inframe = 0;
            mcount = 0;
            flushing = 0;
            @(negedge clk); #1;
            check(txd == 1'b1, "R8 line after reset cmd", txd, 1);
            check(tx_empty == 1'b1, "R8 empty after reset cmd", tx_empty, 1);
        end
    endtask

    task automatic wait_empty(input string req);
        bit ok;
        ok = 0;
        for (int i = 0; i < 30000; i++) begin
            @(posedge clk); #2;
            if (tx_empty && !inframe && q.size() == 0) begin
                ok = 1;
                break;
            end
        end
        check(ok, req, q.size(), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #2;
        check(txd == 1'b1, "R10 line in reset", txd, 1);
        check(tx_empty == 1'b1, "R6 empty in reset", tx_empty, 1);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check(txd == 1'b1 && tx_empty == 1'b1, "R10 idle after reset", {txd, tx_empty}, 3);

        // R7 and R9: queue while disabled, sixth word overflows
        for (int i = 0; i < 6; i++) begin
            wr_wd(32'h000000A0 + 32'(i), i < 5);
        end
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #2;
            if (txd != 1'b1 || tx_empty != 1'b0) begin
                check(0, "R7 held while disabled", {txd, tx_empty}, 2);
                break;
            end
        end
        check(txd == 1'b1 && tx_empty == 1'b0, "R7 held while disabled", {txd, tx_empty}, 2);
        wr_ctl(12'h004, 0);
        wait_empty("R9 five words sent after enable");

        // R1 and R2: counts and byte order
        wr_cnt(4); wr_wd(32'h44332211, 1);
        wait_empty("R2 four bytes in order");
        wr_cnt(3); wr_wd(32'hC3B2A190, 1);
        wr_wd(32'h5A5A5A3C, 1);
        wr_cnt(7); wr_wd(32'h87654321, 1);
        wr_cnt(0); wr_wd(32'h0000EE7E, 1);
        wait_empty("R1 count handling");

        // R3, R4, R5: frame formats
        fmt = 6'h01; wr_cnt(4); wr_wd(32'hF05A3C96, 1); wait_empty("R3 R4 R5 5 odd short");
        fmt = 6'h1A; wr_cnt(4); wr_wd(32'hF05A3C97, 1); wait_empty("R3 R4 R5 6 even long");
        fmt = 6'h2F; wr_cnt(4); wr_wd(32'hF05A3C96, 1); wait_empty("R3 R4 R5 7 space two");
        fmt = 6'h35; wr_cnt(4); wr_wd(32'h0F5A3C69, 1); wait_empty("R4 R5 8 odd one");
        fmt = 6'h06; wr_cnt(2); wr_wd(32'h00001F0E, 1); wait_empty("R4 R5 5 even one");
        fmt = 6'h34;

        // R8: reset command mid-frame
        wr_cnt(4); wr_wd(32'h99887766, 1);
        repeat (400) @(posedge clk);
        wr_ctl(12'h024, 1);
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #2;
            if (txd != 1'b1 || tx_empty != 1'b1) begin
                check(0, "R8 stays flushed", {txd, tx_empty}, 3);
                break;
            end
        end
        wr_wd(32'h000000AB, 1);
        wait_empty("R8 works after reset cmd");

        // R8: pending count flushed
        wr_cnt(4);
        wr_ctl(12'h020, 1);
        wr_wd(32'h44434241, 1);
        wait_empty("R8 count cleared by reset cmd");

        // R8: other commands keep data
        wr_cnt(2); wr_wd(32'h00005566, 1);
        repeat (100) @(posedge clk);
        wr_ctl(12'h824, 0);
        wr_ctl(12'h030, 0);
        wait_empty("R8 other command values ignored");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule